// File: doc/BRIEF.md
# Grouped Register-Programmed Signal Crossbar

This block is a routing fabric that joins peripheral outputs to peripheral inputs the way a set of patch bays would. Signals are sorted into six typed groups: clocks, serial data, frame syncs, pin signals, miscellaneous signals and pin output enables. Each group has its own source list and its own destinations. Each destination owns a 5-bit select field in a memory-mapped register. The value in that field names the source that drives the destination. A source can only reach destinations of its own group. Signals move between groups only through the pin group, with the loopback done outside this block at the pads.

Software programs the fabric through a simple synchronous bus: an address, a write enable, 32-bit write data and a combinational read-back word. Each group has one register, at an address equal to its group index (clock 0, serial data 1, frame sync 2, pin 3, miscellaneous 4, output enable 5). Destination j of a group sits in bits [5j+4:5j]. Any number of fields may hold the same encoding, so a source can fan out without limit. The path from sources to destinations is purely combinational. A new select takes effect on the clock edge that ends the write cycle.

Top module: `grouped_route_xbar`

## Requirements
- R1: While reset is asserted and after it is released, every select field is 0, every destination output is 0, and every register reads back 0.
- R2: A write with cfg_we high to address g (0 to 5) loads bits [5j+4:5j] of cfg_wdata into field j of group g. Reading address g returns those four fields, with bits 31:20 read as 0.
- R3: Encoding 0 drives the destination to constant 0 and encoding 1 drives it to constant 1, whatever the sources do.
- R4: Encoding 2+k, for k from 0 to 9, drives the destination with bit k of its own group's source input.
- R5: Encodings 12 to 31 map to no source, and they drive the destination to constant 0.
- R6: A destination follows only sources of its own group. A write to one group's register leaves the fields of all other groups unchanged.
- R7: The same encoding may be held in all fields of a group at once, and every such destination then carries the same source.
- R8: A source change shows at the selected destinations in the same cycle. A new select appears at the outputs only after the clock edge that ends the write cycle, and the old select stays in force until that edge.
- R9: Writes to addresses 6 to 15 change no field, and reads from those addresses return 0.
- R10: With cfg_we low, no field changes, whatever the values on cfg_addr and cfg_wdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low reset; clears all select fields |
| cfg_addr | input | 4 | Register address; group index 0 to 5 |
| cfg_we | input | 1 | Write strobe |
| cfg_wdata | input | 32 | Write data; four 5-bit fields |
| cfg_rdata | output | 32 | Combinational read-back of the addressed register |
| src_clk | input | 10 | Clock group sources |
| src_sdata | input | 10 | Serial data group sources |
| src_fsync | input | 10 | Frame sync group sources |
| src_pin | input | 10 | Pin group sources |
| src_misc | input | 10 | Miscellaneous group sources |
| src_oe | input | 10 | Output enable group sources |
| dst_clk | output | 4 | Clock group destinations |
| dst_sdata | output | 4 | Serial data group destinations |
| dst_fsync | output | 4 | Frame sync group destinations |
| dst_pin | output | 4 | Pin group destinations |
| dst_misc | output | 4 | Miscellaneous group destinations |
| dst_oe | output | 4 | Output enable group destinations |

## Verification
The hardest case to reach from the ports is a wrong cross-group or wrong-index connection that happens to give the same bit value. A destination that picks the wrong source still matches whenever the two sources carry equal values. The stimulus therefore sets all six groups' sources to independent random words and checks every destination again after each new source pattern. Directed passes also give one group's sources a pattern that is the complement of the other groups' sources. The window of R8 is probed by sampling the outputs between the write setup and the capturing edge, and then again after that edge.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
   localparam int NUM_GROUPS = 6;
   localparam int BUS_W      = 32;

   typedef enum logic [2:0] {
      GRP_CLK   = 3'd0,
      GRP_SDATA = 3'd1,
      GRP_FSYNC = 3'd2,
      GRP_PIN   = 3'd3,
      GRP_MISC  = 3'd4,
      GRP_OE    = 3'd5
   } grp_e;

   // Fixed encodings at the bottom of every group's code space
   localparam int ENC_TIE_LOW   = 0;
   localparam int ENC_TIE_HIGH  = 1;
   localparam int ENC_SRC_BASE  = 2;

   function automatic int ceil_div(input int a, input int b);
      return (a + b - 1) / b;
   endfunction
endpackage

// File: rtl/xbar_sel_regs.sv
module xbar_sel_regs
   import xbar_pkg::*;
#(
   parameter int GROUPS   = NUM_GROUPS,
   parameter int DSTS     = 4,
   parameter int SEL_W    = 5,
   parameter int FPR      = 6,
   parameter int ADDR_W   = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [ADDR_W-1:0]             cfg_addr,
   input  logic                          cfg_we,
   input  logic [BUS_W-1:0]              cfg_wdata,
   output logic [BUS_W-1:0]              cfg_rdata,
   output logic [GROUPS*DSTS*SEL_W-1:0]  sel_flat
);
   localparam int REGS_PER_GRP = ceil_div(DSTS, FPR);
   localparam int NUM_REGS     = GROUPS * REGS_PER_GRP;
   localparam int TOTAL_DSTS   = GROUPS * DSTS;

   if (FPR * SEL_W > BUS_W) begin : g_bad_pack
      $error("xbar_sel_regs: %0d fields of %0d bits exceed the bus", FPR, SEL_W);
   end
   if ((1 << ADDR_W) < NUM_REGS) begin : g_bad_addr
      $error("xbar_sel_regs: address width too small for %0d registers", NUM_REGS);
   end

   logic [SEL_W-1:0] sel_q [TOTAL_DSTS];

   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      for (genvar j = 0; j < DSTS; j++) begin : g_fld
         localparam int IDX = g * DSTS + j;
         localparam int REG = g * REGS_PER_GRP + j / FPR;
         localparam int POS = (j % FPR) * SEL_W;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sel_q[IDX] <= '0;
            end else if (cfg_we && (cfg_addr == ADDR_W'(REG))) begin
               sel_q[IDX] <= cfg_wdata[POS +: SEL_W];
            end
         end
         assign sel_flat[IDX*SEL_W +: SEL_W] = sel_q[IDX];
      end
   end

   always_comb begin
      cfg_rdata = '0;
      for (int i = 0; i < TOTAL_DSTS; i++) begin
         if (cfg_addr == ADDR_W'((i / DSTS) * REGS_PER_GRP + (i % DSTS) / FPR)) begin
            cfg_rdata[((i % DSTS) % FPR) * SEL_W +: SEL_W] = sel_q[i];
         end
      end
   end
endmodule

// File: rtl/xbar_group_mux.sv
module xbar_group_mux
   import xbar_pkg::*;
#(
   parameter int NSRC  = 10,
   parameter int DSTS  = 4,
   parameter int SEL_W = 5,
   parameter int STYLE = 0   // 0: indexed select, 1: decoded AND-OR
) (
   input  logic [NSRC-1:0]        src,
   input  logic [DSTS*SEL_W-1:0]  sel,
   output logic [DSTS-1:0]        dst
);
   localparam int ENC_N = 1 << SEL_W;

   if (NSRC + ENC_SRC_BASE > ENC_N) begin : g_bad_src
      $error("xbar_group_mux: %0d sources do not fit %0d-bit selects", NSRC, SEL_W);
   end
   if (STYLE != 0 && STYLE != 1) begin : g_bad_style
      $error("xbar_group_mux: unknown STYLE %0d", STYLE);
   end

   logic [ENC_N-1:0] code_src;

   always_comb begin
      code_src = '0;
      code_src[ENC_TIE_HIGH] = 1'b1;
      code_src[ENC_SRC_BASE +: NSRC] = src;
   end

   for (genvar j = 0; j < DSTS; j++) begin : g_dst
      logic [SEL_W-1:0] s;
      assign s = sel[j*SEL_W +: SEL_W];
      if (STYLE == 0) begin : g_idx
         assign dst[j] = code_src[s];
      end else begin : g_andor
         logic acc;
         always_comb begin
            acc = 1'b0;
            for (int k = 0; k < ENC_N; k++) begin
               acc = acc | ((s == SEL_W'(k)) & code_src[k]);
            end
         end
         assign dst[j] = acc;
      end
   end
endmodule

// File: rtl/grouped_route_xbar.sv
module grouped_route_xbar
   import xbar_pkg::*;
#(
   parameter int NSRC      = 10,
   parameter int DSTS      = 4,
   parameter int SEL_W     = 5,
   parameter int FPR       = 6,
   parameter int ADDR_W    = 4,
   parameter int MUX_STYLE = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  cfg_addr,
   input  logic               cfg_we,
   input  logic [31:0]        cfg_wdata,
   output logic [31:0]        cfg_rdata,
   input  logic [NSRC-1:0]    src_clk,
   input  logic [NSRC-1:0]    src_sdata,
   input  logic [NSRC-1:0]    src_fsync,
   input  logic [NSRC-1:0]    src_pin,
   input  logic [NSRC-1:0]    src_misc,
   input  logic [NSRC-1:0]    src_oe,
   output logic [DSTS-1:0]    dst_clk,
   output logic [DSTS-1:0]    dst_sdata,
   output logic [DSTS-1:0]    dst_fsync,
   output logic [DSTS-1:0]    dst_pin,
   output logic [DSTS-1:0]    dst_misc,
   output logic [DSTS-1:0]    dst_oe
);
   localparam int GRP_SEL_W = DSTS * SEL_W;

   logic [NUM_GROUPS*NSRC-1:0]      src_all;
   logic [NUM_GROUPS*DSTS-1:0]      dst_all;
   logic [NUM_GROUPS*GRP_SEL_W-1:0] sel_flat;

   assign src_all = {src_oe, src_misc, src_pin, src_fsync, src_sdata, src_clk};
   assign {dst_oe, dst_misc, dst_pin, dst_fsync, dst_sdata, dst_clk} = dst_all;

   xbar_sel_regs #(
      .GROUPS (NUM_GROUPS),
      .DSTS   (DSTS),
      .SEL_W  (SEL_W),
      .FPR    (FPR),
      .ADDR_W (ADDR_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_addr  (cfg_addr),
      .cfg_we    (cfg_we),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .sel_flat  (sel_flat)
   );

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      xbar_group_mux #(
         .NSRC  (NSRC),
         .DSTS  (DSTS),
         .SEL_W (SEL_W),
         .STYLE (MUX_STYLE)
      ) u_mux (
         .src (src_all[g*NSRC +: NSRC]),
         .sel (sel_flat[g*GRP_SEL_W +: GRP_SEL_W]),
         .dst (dst_all[g*DSTS +: DSTS])
      );
   end
endmodule

// File: rtl/grouped_route_xbar_chk.sv
module grouped_route_xbar_chk
   import xbar_pkg::*;
#(
   parameter int NSRC   = 10,
   parameter int DSTS   = 4,
   parameter int SEL_W  = 5,
   parameter int FPR    = 6,
   parameter int ADDR_W = 4
) (
   input logic                                clk,
   input logic                                rst_n,
   input logic [ADDR_W-1:0]                   cfg_addr,
   input logic                                cfg_we,
   input logic [31:0]                         cfg_wdata,
   input logic [31:0]                         cfg_rdata,
   input logic [NUM_GROUPS*DSTS*SEL_W-1:0]    sel_flat,
   input logic [NUM_GROUPS*NSRC-1:0]          src_all,
   input logic [NUM_GROUPS*DSTS-1:0]          dst_all
);
   localparam int REGS_PER_GRP = ceil_div(DSTS, FPR);
   localparam int NUM_REGS     = NUM_GROUPS * REGS_PER_GRP;

   // R10: no write strobe, no field change
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> $stable(sel_flat));

   // R9: writes outside the map leave all fields alone, reads give zero
   p_unmapped_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && (int'(cfg_addr) >= NUM_REGS)) |=> $stable(sel_flat));
   p_unmapped_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(cfg_addr) >= NUM_REGS) |-> (cfg_rdata == '0));

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      for (genvar j = 0; j < DSTS; j++) begin : g_dst
         localparam int IDX = g * DSTS + j;
         localparam int REG = g * REGS_PER_GRP + j / FPR;
         localparam int POS = (j % FPR) * SEL_W;
         logic [SEL_W-1:0] s;
         assign s = sel_flat[IDX*SEL_W +: SEL_W];

         // R2: the addressed write lands in this field
         p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && (cfg_addr == ADDR_W'(REG))) |=>
               (s == $past(cfg_wdata[POS +: SEL_W])));
         // R3: tie-off encodings
         p_tie_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (s == SEL_W'(ENC_TIE_LOW)) |-> !dst_all[IDX]);
         p_tie_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (s == SEL_W'(ENC_TIE_HIGH)) |-> dst_all[IDX]);
         // R4 and R6: a source encoding reaches its own group's source bit
         p_own_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ((int'(s) >= ENC_SRC_BASE) && (int'(s) < ENC_SRC_BASE + NSRC)) |->
               (dst_all[IDX] == src_all[g*NSRC + (int'(s) - ENC_SRC_BASE)]));
         // R5: codes past the source list drive zero
         p_unused_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(s) >= ENC_SRC_BASE + NSRC) |-> !dst_all[IDX]);
      end
   end
endmodule

bind grouped_route_xbar grouped_route_xbar_chk #(
   .NSRC   (NSRC),
   .DSTS   (DSTS),
   .SEL_W  (SEL_W),
   .FPR    (FPR),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_addr  (cfg_addr),
   .cfg_we    (cfg_we),
   .cfg_wdata (cfg_wdata),
   .cfg_rdata (cfg_rdata),
   .sel_flat  (sel_flat),
   .src_all   (src_all),
   .dst_all   (dst_all)
);

// File: tb/tb_grouped_route_xbar.sv
module tb_grouped_route_xbar;
   localparam int NSRC = 10;
   localparam int DSTS = 4;
   localparam int NG   = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  cfg_addr = '0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic [NSRC-1:0] srcv [NG];
   logic [DSTS-1:0] dstv [NG];

   logic [4:0] model [NG][DSTS];
   int vectors = 0;
   int fails   = 0;
   bit done    = 0;

   always #4 clk = ~clk;

   grouped_route_xbar dut (
      .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_we(cfg_we),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .src_clk(srcv[0]), .src_sdata(srcv[1]), .src_fsync(srcv[2]),
      .src_pin(srcv[3]), .src_misc(srcv[4]), .src_oe(srcv[5]),
      .dst_clk(dstv[0]), .dst_sdata(dstv[1]), .dst_fsync(dstv[2]),
      .dst_pin(dstv[3]), .dst_misc(dstv[4]), .dst_oe(dstv[5])
   );

   function automatic logic exp_bit(int g, int j);
      int e = int'(model[g][j]);
      if (e == 0) return 1'b0;
      if (e == 1) return 1'b1;
      if (e < NSRC + 2) return srcv[g][e-2];
      return 1'b0;
   endfunction

   function automatic logic [31:0] exp_reg(int a);
      logic [31:0] r = '0;
      if (a < NG) for (int j = 0; j < DSTS; j++) r[j*5 +: 5] = model[a][j];
      return r;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic check_outs(string req);
      #1;
      for (int g = 0; g < NG; g++)
         for (int j = 0; j < DSTS; j++)
            chk(req, 32'(dstv[g][j]), 32'(exp_bit(g, j)));
   endtask

   task automatic check_reads(string req);
      for (int a = 0; a < 16; a++) begin
         cfg_addr = 4'(a);
         #1;
         chk(req, cfg_rdata, exp_reg(a));
      end
   endtask

   task automatic wr(int a, logic [31:0] d);
      @(negedge clk);
      cfg_addr = 4'(a); cfg_wdata = d; cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
      if (a < NG) for (int j = 0; j < DSTS; j++) model[a][j] = d[j*5 +: 5];
   endtask

   function automatic logic [31:0] pack4(int e0, int e1, int e2, int e3);
      return {12'd0, 5'(e3), 5'(e2), 5'(e1), 5'(e0)};
   endfunction

   task automatic rand_srcs();
      for (int g = 0; g < NG; g++) srcv[g] = NSRC'($urandom);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int g = 0; g < NG; g++) begin
         srcv[g] = '1;
         for (int j = 0; j < DSTS; j++) model[g][j] = '0;
      end
      // R1: during and after reset
      repeat (3) @(negedge clk);
      check_outs("R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      rand_srcs();
      check_outs("R1 after reset");
      check_reads("R1 readback");

      // R3: tie-offs with sources at both polarities
      for (int g = 0; g < NG; g++) wr(g, pack4(0, 1, 1, 0));
      for (int g = 0; g < NG; g++) srcv[g] = '1;
      check_outs("R3 ties, sources high");
      for (int g = 0; g < NG; g++) srcv[g] = '0;
      check_outs("R3 ties, sources low");

      // R2: full-width write, upper bits read as zero
      wr(2, 32'hFFFF_FFFF);
      cfg_addr = 4'd2; #1;
      chk("R2 masked readback", cfg_rdata, 32'h000F_FFFF);

      // R4: every source index in every group, complementary groups (R6)
      for (int k = 0; k < NSRC; k += 4) begin
         for (int g = 0; g < NG; g++)
            wr(g, pack4(k + 2, (k + 1) % NSRC + 2, (k + 2) % NSRC + 2, (k + 3) % NSRC + 2));
         for (int p = 0; p < 4; p++) begin
            rand_srcs();
            srcv[0] = ~srcv[1];
            srcv[3] = ~srcv[4];
            check_outs("R4 R6 source select");
         end
      end
      check_reads("R2 readback of all groups");

      // R5: codes past the list
      for (int g = 0; g < NG; g++) wr(g, pack4(12, 31, 20 + g, 13));
      for (int g = 0; g < NG; g++) srcv[g] = '1;
      check_outs("R5 unused codes");

      // R7: fan-out of one source to every field
      for (int g = 0; g < NG; g++) wr(g, pack4(g + 4, g + 4, g + 4, g + 4));
      for (int p = 0; p < 4; p++) begin
         rand_srcs();
         check_outs("R7 fan-out");
      end

      // R6: write one group, others keep their fields
      wr(3, pack4(2, 3, 4, 5));
      check_reads("R6 other groups unchanged");

      // R8: old select until the capturing edge, source change same cycle
      wr(1, pack4(0, 0, 0, 0));
      @(negedge clk);
      cfg_addr = 4'd1; cfg_wdata = pack4(1, 1, 1, 1); cfg_we = 1'b1;
      #1;
      for (int j = 0; j < DSTS; j++) chk("R8 before edge", 32'(dstv[1][j]), 32'd0);
      @(negedge clk);
      cfg_we = 1'b0;
      for (int j = 0; j < DSTS; j++) model[1][j] = 5'd1;
      for (int j = 0; j < DSTS; j++) chk("R8 after edge", 32'(dstv[1][j]), 32'd1);
      wr(1, pack4(2, 2, 2, 2));
      srcv[1] = '0; #1;
      chk("R8 source low", 32'(dstv[1]), 32'd0);
      srcv[1] = 10'd1; #1;
      chk("R8 source high same cycle", 32'(dstv[1]), 32'hF);

      // R9: unmapped addresses
      for (int a = NG; a < 16; a++) wr(a, $urandom);
      check_reads("R9 unmapped");
      check_outs("R9 outputs unchanged");

      // R10: data and address present without strobe
      @(negedge clk);
      cfg_addr = 4'd0; cfg_wdata = 32'h000F_FFFF; cfg_we = 1'b0;
      repeat (2) @(negedge clk);
      check_reads("R10 no strobe");

      // Random mix
      for (int it = 0; it < 300; it++) begin
         if ($urandom_range(0, 1) == 1) begin
            int a = int'($urandom_range(0, 15));
            logic [31:0] d = $urandom;
            if ($urandom_range(0, 3) == 0) d[19:0] = pack4(0, 1, 2, NSRC + 1);
            wr(a, d);
         end
         rand_srcs();
         check_outs("R4 R5 random");
         if (it % 25 == 0) check_reads("R2 random readback");
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule